// File: doc/BRIEF.md
# Read-Sequence Unlock Command Detector

This block watches the chip-enable-gated read traffic of an asynchronous SRAM-style bus and finds a hidden command channel inside it. The bus controls and address arrive asynchronously. They pass through a synchroniser chain into the system clock domain. Every high-to-low transition of the synchronised chip enable is treated as one bus access ("step"). The access's address and write-enable level are taken at that moment.

A fixed ordered run of five unlock reads, followed by a sixth read, issues a command. The unlock addresses are 0x0E38, 0x31C7, 0x03E0, 0x3C1F and 0x303F. A sixth address of 0x0FC0 requests a store of the array into nonvolatile cells. A sixth address of 0x0C63 requests a recall. The command appears as a single-cycle pulse to the nonvolatile controller. That controller's busy level freezes the detector.

Any foreign access aborts the run. The output-enable level has no bearing on validity, so it is not an input.

Top module: `rseq_cmd_detect`

## Requirements
- R1: After a synchronous active-low reset, `store_req`, `recall_req` and `seq_active` are all low.
- R2: Five reads at 0x0E38, 0x31C7, 0x03E0, 0x3C1F, 0x303F followed by a read at 0x0FC0 produce exactly one `store_req` pulse. No earlier write history is required.
- R3: The same five unlock reads followed by a read at 0x0C63 produce exactly one `recall_req` pulse.
- R4: Only address bits 13:0 are compared. A sequence with bit 14 set on every access behaves as if bit 14 were clear.
- R5: A step is taken only on a high-to-low transition of the synchronised `ce_n`. Address changes while `ce_n` stays low take no step. A second fall on an address already consumed aborts the run.
- R6: An access with `we_n` low at the chip-enable fall aborts the run to idle. Its address does not restart a run, and no command follows.
- R7: A read at an address other than the expected next one aborts the run. If that address is 0x0E38, it becomes step one of a new run.
- R8: `seq_active` is high exactly while one to five unlock steps have been accepted.
- R9: While `busy` is high, the step count is forced to zero and chip-enable falls are ignored.
- R10: A sixth read at any address other than the two command addresses aborts with no pulse.
- R11: `store_req` and `recall_req` are each one cycle wide and never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| busy | input | 1 | Nonvolatile transfer in progress (clock-domain level) |
| ce_n | input | 1 | Asynchronous chip enable, active low |
| we_n | input | 1 | Asynchronous write enable, active low |
| addr | input | 15 | Asynchronous bus address |
| store_req | output | 1 | One-cycle store command pulse |
| recall_req | output | 1 | One-cycle recall command pulse |
| seq_active | output | 1 | Unlock run in progress |

## Verification
The bench builds the block with a three-stage synchroniser rather than the default two. This shows that command detection and the abort rules do not depend on a particular input latency. The same setting also shows that pulses are placed correctly behind a deeper chain. Address width and match width keep their defaults. This brings bit 14 into reach as a don't-care bit next to the fourteen compared bits.

// File: rtl/rseq_pkg.sv
// Shared constants and types for the read-sequence command detector.
// Assumes a 15-bit bus address with the low 14 bits significant for matching.
package rseq_pkg;
    localparam int ADDR_W   = 15;
    localparam int MATCH_W  = 14;
    localparam int N_UNLOCK = 5;

    localparam logic [ADDR_W-1:0] STORE_ADDR  = 15'h0FC0;
    localparam logic [ADDR_W-1:0] RECALL_ADDR = 15'h0C63;

    typedef enum logic [1:0] {
        CMD_NONE   = 2'd0,
        CMD_STORE  = 2'd1,
        CMD_RECALL = 2'd2
    } cmd_e;

    // Unlock address for a given step index, in required order.
    function automatic logic [ADDR_W-1:0] unlock_key(input int idx);
        case (idx)
            0:       unlock_key = 15'h0E38;
            1:       unlock_key = 15'h31C7;
            2:       unlock_key = 15'h03E0;
            3:       unlock_key = 15'h3C1F;
            default: unlock_key = 15'h303F;
        endcase
    endfunction
endpackage

// File: rtl/rseq_sync.sv
// Multi-stage synchroniser for a bundle of asynchronous levels.
// Assumes each bit is individually quasi-static around a sampling edge;
// reset loads a caller-chosen idle value.
module rseq_sync #(
    parameter int              W       = 17,
    parameter int              STAGES  = 2,
    parameter logic [W-1:0]    RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [STAGES-1:0][W-1:0] chain;

    // Shift the asynchronous inputs through the flop chain.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int s = 0; s < STAGES; s++) chain[s] <= RST_VAL;
        end else begin
            chain[0] <= d;
            for (int s = 1; s < STAGES; s++) chain[s] <= chain[s-1];
        end
    end

    assign q = chain[STAGES-1];
endmodule

// File: rtl/rseq_edge.sv
// Turns synchronised bus levels into step events: one event per
// high-to-low transition of chip enable, carrying address and write flag.
// Assumes inputs are already in the clock domain.
module rseq_edge #(
    parameter int ADDR_W = 15
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ce_s,
    input  logic              we_s,
    input  logic [ADDR_W-1:0] addr_s,
    output logic              step_vld,
    output logic              step_wr,
    output logic [ADDR_W-1:0] step_addr
);
    logic ce_prev;

    // Remember last chip-enable level; idle level is high.
    always_ff @(posedge clk) begin
        if (!rst_n) ce_prev <= 1'b1;
        else        ce_prev <= ce_s;
    end

    assign step_vld  = ce_prev & ~ce_s;
    assign step_wr   = ~we_s;
    assign step_addr = addr_s;
endmodule

// File: rtl/rseq_match.sv
// Step counter and command decoder for the unlock run.
// Assumes step_vld is a single-cycle event; busy is a clock-domain level.
module rseq_match
    import rseq_pkg::*;
#(
    parameter int ADDR_W   = rseq_pkg::ADDR_W,
    parameter int MATCH_W  = rseq_pkg::MATCH_W,
    parameter int N_UNLOCK = rseq_pkg::N_UNLOCK
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              busy,
    input  logic              step_vld,
    input  logic              step_wr,
    input  logic [ADDR_W-1:0] step_addr,
    output logic              store_req,
    output logic              recall_req,
    output logic              seq_active
);
    localparam int              STEP_W = $clog2(N_UNLOCK + 1);
    localparam logic [ADDR_W-1:0] MASK = ADDR_W'((1 << MATCH_W) - 1);
    localparam logic [STEP_W-1:0] LAST = STEP_W'(N_UNLOCK);

    logic [N_UNLOCK-1:0] key_hit;
    logic                store_hit, recall_hit, exp_hit;
    logic [STEP_W-1:0]   step_q, step_d;
    cmd_e                cmd_d;

    // One masked comparator per unlock key.
    for (genvar i = 0; i < N_UNLOCK; i++) begin : g_key
        assign key_hit[i] = ((step_addr ^ unlock_key(i)) & MASK) == '0;
    end
    assign store_hit  = ((step_addr ^ STORE_ADDR)  & MASK) == '0;
    assign recall_hit = ((step_addr ^ RECALL_ADDR) & MASK) == '0;

    // Select the comparator for the step now expected.
    always_comb begin
        exp_hit = 1'b0;
        for (int i = 0; i < N_UNLOCK; i++)
            if (step_q == STEP_W'(i)) exp_hit = key_hit[i];
    end

    // Next step count and command choice.
    always_comb begin
        step_d = step_q;
        cmd_d  = CMD_NONE;
        if (busy) begin
            step_d = '0;
        end else if (step_vld) begin
            if (step_wr) begin
                step_d = '0;
            end else if (step_q == LAST) begin
                if (store_hit)       cmd_d = CMD_STORE;
                else if (recall_hit) cmd_d = CMD_RECALL;
                step_d = (cmd_d == CMD_NONE && key_hit[0]) ? STEP_W'(1) : '0;
            end else if (exp_hit) begin
                step_d = step_q + STEP_W'(1);
            end else begin
                step_d = key_hit[0] ? STEP_W'(1) : '0;
            end
        end
    end

    // Register step count and command pulses.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            step_q     <= '0;
            store_req  <= 1'b0;
            recall_req <= 1'b0;
        end else begin
            step_q     <= step_d;
            store_req  <= (cmd_d == CMD_STORE);
            recall_req <= (cmd_d == CMD_RECALL);
        end
    end

    assign seq_active = (step_q != '0);
endmodule

// File: rtl/rseq_cmd_detect.sv
// Top: synchronises the bus, detects chip-enable falls and decodes the
// six-access unlock run into store / recall pulses.
// Assumes ce_n, we_n and addr are asynchronous; busy is synchronous.
module rseq_cmd_detect
    import rseq_pkg::*;
#(
    parameter int ADDR_W      = rseq_pkg::ADDR_W,
    parameter int MATCH_W     = rseq_pkg::MATCH_W,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              busy,
    input  logic              ce_n,
    input  logic              we_n,
    input  logic [ADDR_W-1:0] addr,
    output logic              store_req,
    output logic              recall_req,
    output logic              seq_active
);
    localparam int             BUS_W   = ADDR_W + 2;
    localparam logic [BUS_W-1:0] BUS_IDLE = {2'b11, {ADDR_W{1'b0}}};

    logic [BUS_W-1:0]  bus_s;
    logic              step_vld, step_wr;
    logic [ADDR_W-1:0] step_addr;

    rseq_sync #(.W(BUS_W), .STAGES(SYNC_STAGES), .RST_VAL(BUS_IDLE)) u_sync (
        .clk (clk), .rst_n (rst_n),
        .d   ({ce_n, we_n, addr}),
        .q   (bus_s)
    );

    rseq_edge #(.ADDR_W(ADDR_W)) u_edge (
        .clk (clk), .rst_n (rst_n),
        .ce_s (bus_s[BUS_W-1]), .we_s (bus_s[BUS_W-2]), .addr_s (bus_s[ADDR_W-1:0]),
        .step_vld (step_vld), .step_wr (step_wr), .step_addr (step_addr)
    );

    rseq_match #(.ADDR_W(ADDR_W), .MATCH_W(MATCH_W), .N_UNLOCK(N_UNLOCK)) u_match (
        .clk (clk), .rst_n (rst_n), .busy (busy),
        .step_vld (step_vld), .step_wr (step_wr), .step_addr (step_addr),
        .store_req (store_req), .recall_req (recall_req), .seq_active (seq_active)
    );
endmodule

// File: rtl/rseq_checker.sv
// Protocol checks on the detector's outputs; bound to the top module.
module rseq_checker (
    input logic clk,
    input logic rst_n,
    input logic busy,
    input logic store_req,
    input logic recall_req,
    input logic seq_active
);
    // R11: pulses never overlap
    a_r11_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(store_req && recall_req));
    // R11: store pulse lasts one cycle
    a_r11_store_one: assert property (@(posedge clk) disable iff (!rst_n)
        store_req |=> !store_req);
    // R11: recall pulse lasts one cycle
    a_r11_recall_one: assert property (@(posedge clk) disable iff (!rst_n)
        recall_req |=> !recall_req);
    // R2: store only ends an active run, which then closes
    a_r2_store_end: assert property (@(posedge clk) disable iff (!rst_n)
        store_req |-> ($past(seq_active) && !seq_active));
    // R3: recall only ends an active run, which then closes
    a_r3_recall_end: assert property (@(posedge clk) disable iff (!rst_n)
        recall_req |-> ($past(seq_active) && !seq_active));
    // R9: busy clears the run and suppresses commands
    a_r9_busy_hold: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> (!seq_active && !store_req && !recall_req));
endmodule

bind rseq_cmd_detect rseq_checker u_chk (
    .clk (clk), .rst_n (rst_n), .busy (busy),
    .store_req (store_req), .recall_req (recall_req), .seq_active (seq_active)
);

// File: tb/sim_rseq_cmd_detect.sv
module sim_rseq_cmd_detect;
    localparam int CLK_PERIOD = 10;
    localparam int CMD_S = 1;
    localparam int CMD_R = 2;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        busy = 1'b0;
    logic        ce_n = 1'b1;
    logic        we_n = 1'b1;
    logic [14:0] addr = '0;
    logic        store_req, recall_req, seq_active;

    int checks = 0;
    int errors = 0;
    int exp_q[$];
    bit done = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    rseq_cmd_detect #(.SYNC_STAGES(3)) u0 (
        .clk (clk), .rst_n (rst_n), .busy (busy), .ce_n (ce_n), .we_n (we_n),
        .addr (addr), .store_req (store_req), .recall_req (recall_req),
        .seq_active (seq_active)
    );

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic access(input logic [14:0] a, input logic wr);
        @(negedge clk);
        addr = a; we_n = ~wr;
        repeat (2) @(negedge clk);
        ce_n = 1'b0;
        repeat (5) @(negedge clk);
        ce_n = 1'b1;
        repeat (2) @(negedge clk);
        we_n = 1'b1;
        repeat (3) @(negedge clk);
    endtask

    task automatic rd(input logic [14:0] a); access(a, 1'b0); endtask
    task automatic wr(input logic [14:0] a); access(a, 1'b1); endtask

    task automatic unlock(input logic [14:0] hi);
        rd(15'h0E38 | hi); rd(15'h31C7 | hi); rd(15'h03E0 | hi);
        rd(15'h3C1F | hi); rd(15'h303F | hi);
    endtask

    task automatic report;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    // Monitor: pop expected commands as pulses appear, check widths.
    initial begin
        bit prev_pulse = 0;
        forever begin
            @(negedge clk);
            if (rst_n) begin
                if (store_req || recall_req) begin
                    check("R11 width/exclusive", int'(prev_pulse) + int'(store_req && recall_req), 0);
                    if (exp_q.size() == 0)
                        check("R6/R7/R10 unexpected command", store_req ? CMD_S : CMD_R, 0);
                    else
                        check("R2/R3 command kind", store_req ? CMD_S : CMD_R, exp_q.pop_front());
                end
                prev_pulse = store_req || recall_req;
            end
        end
    end

    // Watchdog
    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            report();
        end
    end

    initial begin
        repeat (4) @(negedge clk);
        check("R1 store_req", store_req, 0);
        check("R1 recall_req", recall_req, 0);
        check("R1 seq_active", seq_active, 0);
        rst_n = 1'b1;
        repeat (4) @(negedge clk);
        check("R1 idle after reset", seq_active, 0);

        // R2 / R8: store run with seq_active tracking
        rd(15'h0E38); check("R8 after step1", seq_active, 1);
        rd(15'h31C7); rd(15'h03E0); rd(15'h3C1F);
        rd(15'h303F); check("R8 after step5", seq_active, 1);
        exp_q.push_back(CMD_S);
        rd(15'h0FC0);
        check("R2 store issued", exp_q.size(), 0);
        check("R8 idle after command", seq_active, 0);

        // R3: recall
        unlock(15'h0); exp_q.push_back(CMD_R); rd(15'h0C63);
        check("R3 recall issued", exp_q.size(), 0);

        // R4: bit 14 set everywhere
        unlock(15'h4000); exp_q.push_back(CMD_S); rd(15'h4FC0);
        check("R4 store with bit14", exp_q.size(), 0);

        // R6: write aborts
        rd(15'h0E38); rd(15'h31C7); wr(15'h03E0);
        check("R6 write aborts", seq_active, 0);
        rd(15'h3C1F); rd(15'h303F); rd(15'h0FC0);
        wr(15'h0E38);
        check("R6 write to first key no restart", seq_active, 0);

        // R7: wrong address aborts
        rd(15'h0E38); rd(15'h31C7); rd(15'h1234);
        check("R7 wrong address aborts", seq_active, 0);
        rd(15'h03E0); rd(15'h3C1F); rd(15'h303F); rd(15'h0C63);

        // R7: first key restarts a run
        rd(15'h0E38); rd(15'h31C7); rd(15'h03E0); rd(15'h0E38);
        check("R7 restart on first key", seq_active, 1);
        rd(15'h31C7); rd(15'h03E0); rd(15'h3C1F); rd(15'h303F);
        exp_q.push_back(CMD_S); rd(15'h0FC0);
        check("R7 store after restart", exp_q.size(), 0);

        // R5: repeated fall on same address
        rd(15'h0E38); rd(15'h31C7); rd(15'h31C7);
        check("R5 repeated fall aborts", seq_active, 0);
        rd(15'h03E0); rd(15'h3C1F); rd(15'h303F); rd(15'h0FC0);

        // R5: address change while CE low is not a step
        @(negedge clk); addr = 15'h0E38; we_n = 1'b1;
        repeat (2) @(negedge clk); ce_n = 1'b0;
        repeat (5) @(negedge clk); addr = 15'h31C7;
        repeat (5) @(negedge clk); ce_n = 1'b1;
        repeat (5) @(negedge clk);
        check("R5 one step for long access", seq_active, 1);
        rd(15'h03E0);
        check("R5 no hidden step", seq_active, 0);

        // R10: bad sixth address
        unlock(15'h0); rd(15'h0FC1);
        check("R10 bad sixth aborts", seq_active, 0);

        // R9: busy freezes the detector
        rd(15'h0E38); rd(15'h31C7);
        @(negedge clk); busy = 1'b1;
        repeat (2) @(negedge clk);
        check("R9 busy clears run", seq_active, 0);
        rd(15'h0E38);
        check("R9 fall ignored while busy", seq_active, 0);
        unlock(15'h0); rd(15'h0FC0);
        @(negedge clk); busy = 1'b0;
        repeat (3) @(negedge clk);
        check("R9 still idle after busy", seq_active, 0);
        unlock(15'h0); exp_q.push_back(CMD_R); rd(15'h0C63);
        check("R9 works after busy", exp_q.size(), 0);

        repeat (10) @(negedge clk);
        check("R2/R3 queue drained", exp_q.size(), 0);
        done = 1;
        report();
    end
endmodule